// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the running address for a four-beat burst. An external start address is captured on a load command. After that, each advance command moves the two low-order address bits to the next beat of the burst. The bits above them stay as they were loaded. After the fourth beat the low bits come back to the start value, so a burst that keeps advancing cycles through the same four addresses.

Two beat orderings are supported. In linear ordering, the low bits count up from the start value modulo four. In interleaved ordering, the low bits are the start value XOR a two-bit beat count. A mode pin picks the ordering. The pin is meant to be static and is sampled only when a burst is loaded. An active-low clock enable freezes the whole sequencer. The output address is taken straight from registers, so a load or advance shows up at the output right after the clock edge that accepts it.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst` is high at a rising edge, the sequencer clears: `addr` reads 0 and linear ordering is selected, whatever the other inputs are.
- R2: At a rising edge with `ce_n` = 0 and `adv_n` = 0, `ext_addr` is captured as the burst start, and `addr` equals it after that edge.
- R3: At a rising edge with `ce_n` = 0 and `adv_n` = 1, the beat count goes up by one (modulo 4), and `addr` moves to the next beat of the current burst.
- R4: With interleaved ordering (`mode_ilv` = 1 at load), the low bits are start XOR beat. Starting at 01 this gives 01,00,11,10. Starting at 10 it gives 10,11,00,01. Starting at 11 it gives 11,10,01,00.
- R5: With linear ordering (`mode_ilv` = 0 at load), the low bits are (start + beat) mod 4. Starting at 01 this gives 01,10,11,00. Starting at 11 it gives 11,00,01,10.
- R6: The advance that follows the fourth beat returns `addr` to the loaded start address.
- R7: While `ce_n` = 1, `addr` and the internal burst state hold, and `adv_n`, `mode_ilv` and `ext_addr` have no effect.
- R8: Address bits `addr[ADDR_W-1:2]` never change on an advance. They only take new values on a load.
- R9: A change of `mode_ilv` between loads has no effect. The ordering latched at the last load stays in force until the next load.
- R10: A load during a burst restarts at beat 0 from the new start address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Active-low clock enable; high freezes the sequencer |
| adv_n | input | 1 | Low: load start address; high: advance one beat |
| mode_ilv | input | 1 | Ordering select sampled at load: 1 interleaved, 0 linear |
| ext_addr | input | ADDR_W | External burst start address |
| addr | output | ADDR_W | Current burst address |

## Verification
The assertions assume that `ce_n`, `adv_n`, `mode_ilv` and `ext_addr` are known and settled at each rising edge. They also assume that `rst` is high at the first edge, so that the checker's own record of the loaded start, ordering and beat count starts in step with the design. The bench changes every input only on the falling clock edge and holds reset through several edges before it releases it. It then drives loads, advances and stalls in mixed orders. This includes changing the mode and the external address while stalled or mid-burst, so the flip and hold properties see both orderings and every beat parity.

// File: rtl/bas_pkg.sv
package bas_pkg;

    localparam int unsigned LOW_W    = 2;
    localparam int unsigned N_BEATS  = 1 << LOW_W;

    typedef enum logic [1:0] {
        CMD_HOLD = 2'd0,
        CMD_LOAD = 2'd1,
        CMD_STEP = 2'd2
    } cmd_e;

    typedef enum logic {
        ORD_LINEAR      = 1'b0,
        ORD_INTERLEAVED = 1'b1
    } order_e;

    typedef struct packed {
        logic [LOW_W-1:0] start_lo;
        logic [LOW_W-1:0] beat;
        order_e           order;
    } burst_state_t;

    localparam burst_state_t STATE_RESET = '{
        start_lo: '0,
        beat:     '0,
        order:    ORD_LINEAR
    };

    function automatic logic [LOW_W-1:0] beat_next(input logic [LOW_W-1:0] b);
        return b + LOW_W'(1);
    endfunction

    function automatic cmd_e decode_cmd(input logic ce_n, input logic adv_n);
        if (ce_n)
            return CMD_HOLD;
        else if (!adv_n)
            return CMD_LOAD;
        else
            return CMD_STEP;
    endfunction

endpackage

// File: rtl/bas_cmd_decode.sv
module bas_cmd_decode
    import bas_pkg::*;
(
    input  logic ce_n,
    input  logic adv_n,
    output cmd_e cmd
);

    always_comb begin
        cmd = decode_cmd(ce_n, adv_n);
    end

endmodule

// File: rtl/bas_state_reg.sv
module bas_state_reg
    import bas_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    localparam int unsigned UP_W  = ADDR_W - LOW_W
) (
    input  logic              clk,
    input  logic              rst,
    input  cmd_e              cmd,
    input  logic              mode_ilv,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [UP_W-1:0]   upper_q,
    output burst_state_t      state_q
);

    burst_state_t     state_d;
    logic [UP_W-1:0]  upper_d;

    always_comb begin
        state_d = state_q;
        upper_d = upper_q;
        unique case (cmd)
            CMD_LOAD: begin
                upper_d          = ext_addr[ADDR_W-1:LOW_W];
                state_d.start_lo = ext_addr[LOW_W-1:0];
                state_d.beat     = '0;
                state_d.order    = mode_ilv ? ORD_INTERLEAVED : ORD_LINEAR;
            end
            CMD_STEP: begin
                state_d.beat = beat_next(state_q.beat);
            end
            default: begin
                state_d = state_q;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= STATE_RESET;
            upper_q <= '0;
        end else begin
            state_q <= state_d;
            upper_q <= upper_d;
        end
    end

endmodule

// File: rtl/bas_order_map.sv
module bas_order_map
    import bas_pkg::*;
(
    input  burst_state_t     state,
    output logic [LOW_W-1:0] low_addr
);

    logic [LOW_W-1:0] lin_lo;
    logic [LOW_W-1:0] ilv_lo;

    assign lin_lo = state.start_lo + state.beat;

    for (genvar i = 0; i < LOW_W; i++) begin : g_ilv_bit
        assign ilv_lo[i] = state.start_lo[i] ^ state.beat[i];
    end

    always_comb begin
        unique case (state.order)
            ORD_INTERLEAVED: low_addr = ilv_lo;
            default:         low_addr = lin_lo;
        endcase
    end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import bas_pkg::*;
#(
    parameter int unsigned ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              adv_n,
    input  logic              mode_ilv,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] addr
);

    localparam int unsigned UP_W = ADDR_W - LOW_W;

    cmd_e             cmd;
    burst_state_t     state_q;
    logic [UP_W-1:0]  upper_q;
    logic [LOW_W-1:0] low_addr;

    bas_cmd_decode u_dec (
        .ce_n  (ce_n),
        .adv_n (adv_n),
        .cmd   (cmd)
    );

    bas_state_reg #(.ADDR_W(ADDR_W)) u_state (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .mode_ilv (mode_ilv),
        .ext_addr (ext_addr),
        .upper_q  (upper_q),
        .state_q  (state_q)
    );

    bas_order_map u_map (
        .state    (state_q),
        .low_addr (low_addr)
    );

    assign addr = {upper_q, low_addr};

endmodule

// File: rtl/bas_checker.sv
module bas_checker
    import bas_pkg::*;
#(
    parameter int unsigned ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              ce_n,
    input logic              adv_n,
    input logic              mode_ilv,
    input logic [ADDR_W-1:0] ext_addr,
    input logic [ADDR_W-1:0] addr
);

    logic             seen_ilv;
    logic             seen_load;
    logic [1:0]       seen_start;
    logic [1:0]       adv_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_ilv   <= 1'b0;
            seen_load  <= 1'b0;
            seen_start <= 2'b00;
            adv_cnt    <= 2'b00;
        end else if (!ce_n) begin
            if (!adv_n) begin
                seen_ilv   <= mode_ilv;
                seen_load  <= 1'b1;
                seen_start <= ext_addr[1:0];
                adv_cnt    <= 2'b00;
            end else begin
                adv_cnt <= adv_cnt + 2'd1;
            end
        end
    end

    // R1: first edge out of reset starts from address zero
    a_r1_reset_zero: assert property (@(posedge clk)
        rst |=> (addr == '0));

    a_r2_load_captures: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && !adv_n) |=> (addr == $past(ext_addr)));

    a_r7_hold_when_disabled: assert property (@(posedge clk) disable iff (rst)
        ce_n |=> $stable(addr));

    a_r8_upper_fixed: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && adv_n) |=> (addr[ADDR_W-1:2] == $past(addr[ADDR_W-1:2])));

    // R3, R5, R9: linear step always adds one to the low bits
    a_r5_linear_step: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && adv_n && !seen_ilv) |=> (addr[1:0] == 2'($past(addr[1:0]) + 2'd1)));

    // R3, R4, R9: interleaved step from an even beat flips bit 0 only
    a_r4_ilv_even_step: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && adv_n && seen_ilv && !adv_cnt[0]) |=> ((addr[1:0] ^ $past(addr[1:0])) == 2'b01));

    // R3, R4, R9: interleaved step from an odd beat flips both bits
    a_r4_ilv_odd_step: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && adv_n && seen_ilv && adv_cnt[0]) |=> ((addr[1:0] ^ $past(addr[1:0])) == 2'b11));

    a_r6_wrap_to_start: assert property (@(posedge clk) disable iff (rst)
        (seen_load && adv_cnt == 2'b00) |-> (addr[1:0] == seen_start));

endmodule

bind burst_addr_seq bas_checker #(.ADDR_W(ADDR_W)) u_bas_chk (
    .clk      (clk),
    .rst      (rst),
    .ce_n     (ce_n),
    .adv_n    (adv_n),
    .mode_ilv (mode_ilv),
    .ext_addr (ext_addr),
    .addr     (addr)
);

// File: tb/burst_addr_seq_bench.sv
`timescale 1ns/1ps
module burst_addr_seq_bench;

    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic          ce_n;
    logic          adv_n;
    logic          mode_ilv;
    logic [AW-1:0] ext_addr;
    logic [AW-1:0] addr;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    int m_upper;
    int m_start;
    int m_beat;
    int m_ilv;

    always #10 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW)) u_burst_addr_seq (
        .clk      (clk),
        .rst      (rst),
        .ce_n     (ce_n),
        .adv_n    (adv_n),
        .mode_ilv (mode_ilv),
        .ext_addr (ext_addr),
        .addr     (addr)
    );

    function automatic int model_addr();
        int lo;
        if (m_ilv != 0) lo = m_start ^ m_beat;
        else            lo = (m_start + m_beat) % 4;
        return (m_upper * 4) + lo;
    endfunction

    task automatic check_val(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One clock: drive at falling edge, update model, sample after rising edge
    task automatic cyc(input logic ce, input logic adv, input logic md,
                       input logic [AW-1:0] a, input string req);
        @(negedge clk);
        ce_n = ce; adv_n = adv; mode_ilv = md; ext_addr = a;
        if (!ce) begin
            if (!adv) begin
                m_upper = int'(a) / 4;
                m_start = int'(a) % 4;
                m_beat  = 0;
                m_ilv   = md ? 1 : 0;
            end else begin
                m_beat = (m_beat + 1) % 4;
            end
        end
        @(posedge clk);
        #2;
        check_val(req, int'(addr), model_addr());
    endtask

    // Load then three advances plus one wrap, with literal low-bit sequence
    task automatic burst(input logic md, input logic [AW-1:0] a,
                         input logic [1:0] e0, input logic [1:0] e1,
                         input logic [1:0] e2, input logic [1:0] e3, input string req);
        cyc(1'b0, 1'b0, md, a, req);
        check_val(req, int'(addr[1:0]), int'(e0));
        cyc(1'b0, 1'b1, md, 16'h0000, req);
        check_val(req, int'(addr[1:0]), int'(e1));
        cyc(1'b0, 1'b1, md, 16'hFFFF, req);
        check_val(req, int'(addr[1:0]), int'(e2));
        cyc(1'b0, 1'b1, md, 16'h1234, req);
        check_val(req, int'(addr[1:0]), int'(e3));
        cyc(1'b0, 1'b1, md, 16'h0000, "R6 wrap");
        check_val("R6 wrap", int'(addr), int'(a));
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; ce_n = 1'b0; adv_n = 1'b0; mode_ilv = 1'b1; ext_addr = 16'hFFFF;
        m_upper = 0; m_start = 0; m_beat = 0; m_ilv = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0; ce_n = 1'b1;
        #1;
        check_val("R1 reset", int'(addr), 0);

        // R1: reset left linear ordering; advancing counts up
        cyc(1'b0, 1'b1, 1'b1, 16'hFFFF, "R1 linear after reset");
        check_val("R1 linear after reset", int'(addr), 1);

        // R4 interleaved orderings
        burst(1'b1, 16'hABC1, 2'b01, 2'b00, 2'b11, 2'b10, "R4 ilv start 01");
        burst(1'b1, 16'h5552, 2'b10, 2'b11, 2'b00, 2'b01, "R4 ilv start 10");
        burst(1'b1, 16'h00F3, 2'b11, 2'b10, 2'b01, 2'b00, "R4 ilv start 11");
        // R5 linear orderings
        burst(1'b0, 16'h7E01, 2'b01, 2'b10, 2'b11, 2'b00, "R5 lin start 01");
        burst(1'b0, 16'hC0DF, 2'b11, 2'b00, 2'b01, 2'b10, "R5 lin start 11");

        // R8: upper bits kept across a long advance run
        cyc(1'b0, 1'b0, 1'b0, 16'hABCD, "R2 load");
        for (int i = 0; i < 9; i++) begin
            cyc(1'b0, 1'b1, 1'b0, 16'h0000, "R8 upper");
            check_val("R8 upper", int'(addr[AW-1:2]), int'(16'hABCD >> 2));
        end

        // R7: disabled cycles ignore every other input
        cyc(1'b0, 1'b0, 1'b1, 16'h3216, "R2 load");
        cyc(1'b0, 1'b1, 1'b1, 16'h0000, "R3 step");
        cyc(1'b1, 1'b0, 1'b0, 16'h9999, "R7 hold load ignored");
        check_val("R7 hold load ignored", int'(addr), int'(16'h3217));
        cyc(1'b1, 1'b1, 1'b0, 16'h0000, "R7 hold step ignored");
        check_val("R7 hold step ignored", int'(addr), int'(16'h3217));
        cyc(1'b0, 1'b1, 1'b0, 16'h0000, "R7 resume interleaved");
        check_val("R7 resume interleaved", int'(addr), int'(16'h3214));

        // R9: mode change between loads has no effect
        cyc(1'b0, 1'b0, 1'b0, 16'h0101, "R2 load");
        cyc(1'b0, 1'b1, 1'b1, 16'h0000, "R9 mode ignored");
        check_val("R9 mode ignored", int'(addr[1:0]), 2);
        cyc(1'b0, 1'b1, 1'b1, 16'h0000, "R9 mode ignored");
        check_val("R9 mode ignored", int'(addr[1:0]), 3);

        // R10: reload mid-burst restarts at beat 0
        cyc(1'b0, 1'b0, 1'b1, 16'h4442, "R10 reload");
        check_val("R10 reload", int'(addr), int'(16'h4442));
        cyc(1'b0, 1'b1, 1'b0, 16'h0000, "R10 reload step");
        check_val("R10 reload step", int'(addr[1:0]), 3);

        // Mixed pattern compared against the model every clock
        for (int i = 0; i < 60; i++) begin
            cyc(((i % 7) == 3), ((i % 5) != 0), ((i % 3) == 1),
                AW'((i * 16'h2F1B) ^ 16'h5A5A), "R3 mixed");
        end

        // R1: reset mid-burst clears again
        @(negedge clk);
        rst = 1'b1; ce_n = 1'b0; adv_n = 1'b1;
        @(posedge clk);
        #2;
        m_upper = 0; m_start = 0; m_beat = 0; m_ilv = 0;
        check_val("R1 reset again", int'(addr), 0);
        @(negedge clk);
        rst = 1'b0;

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule